// File: doc/BRIEF.md
# Codec Serial Control Port

This block is the slave side of a chip-select framed serial control link for a voice codec. An external controller shifts command bytes in on a control clock and a serial data line while it holds an active-low select. Each command byte carries the requested power state, a 4-bit register address, a read/write flag and a one-byte/two-byte flag. A one-byte command changes only the power state. A two-byte command either writes the following byte into one of sixteen 8-bit registers or shifts that register's contents back out on the serial output.

The serial pins are sampled by the block's system clock, which must run well above the control clock. The second byte of a two-byte command may follow the first inside the same select window or in a later one. Several commands may be chained without raising the select. The serial output is released (its enable is low) whenever the select is high, so several slaves can share one return line. The register contents are offered as one flat bus for the rest of the codec, together with a power-up flag.

Top module: `codec_ctl_port`

## Requirements
- R1: After reset every register reads 0, `powered_o` is 0 and the next complete byte is treated as a command byte.
- R2: While `csn_i` is low, `sdi_i` is captured on each falling edge of `sclk_i`, most significant bit first, and eight captures form one byte.
- R3: A command byte with bit 1 = 0 is a one-byte command: `powered_o` takes bit 7 (1 = powered up) and no register changes, whatever bits 6..3 and 2 hold.
- R4: A command byte with bit 1 = 1 and bit 2 = 0 is a write: `powered_o` takes bit 7, and the next complete byte is stored in the register addressed by bits 6..3 (register n appears on `regs_o[8n+7:8n]`).
- R5: A command byte with bits 2 and 1 both set is a read: during the next byte, each rising `sclk_i` edge puts the next bit of the addressed register on `sdo_o`, most significant bit first. The bits arriving on `sdi_i` during that byte change no register.
- R6: The second byte of a two-byte command is accepted whether it follows in the same select-low window or in a new one.
- R7: `sdo_oe_o` is 1 exactly while `csn_i` is low.
- R8: Raising `csn_i` before a byte is complete discards the bits of that byte but keeps any pending second-byte expectation.
- R9: Bit 0 of a command byte has no effect on the command.
- R10: After the second byte of a two-byte command, the next byte is again a command, so commands may be chained within one select-low window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial control clock from the controller |
| sdi_i | input | 1 | Serial data into the port |
| csn_i | input | 1 | Active-low chip select |
| sdo_o | output | 1 | Serial data out for reads |
| sdo_oe_o | output | 1 | Output enable for the serial data out |
| powered_o | output | 1 | Power state requested by the last command (1 = up) |
| regs_o | output | 128 | All sixteen registers, register n on bits 8n+7..8n |

## Verification
On every cycle the embedded assertions check several rules. The bit counter returns to zero and no byte completes while the select is high. A register write happens only while a data byte is expected, and never to more than one register at a time. The power flag moves only when a command byte completes. The port returns to command decoding after each second byte. The bench scenarios cover the rest: the mapping of command fields to power, address and direction; the bit order seen on the serial output during reads; contiguous and split second bytes; chained commands; and the discarding of aborted partial bytes in both the command and data phases.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

    localparam int DW   = 8;
    localparam int AW   = 4;
    localparam int NREG = 1 << AW;
    localparam int CW   = $clog2(DW);

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_WDATA = 2'd1,
        ST_RDATA = 2'd2
    } port_state_e;

    // Layout of a command byte, MSB first.
    typedef struct packed {
        logic          pwr_up;
        logic [AW-1:0] addr;
        logic          is_read;
        logic          two_byte;
        logic          unused;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [DW-1:0] b);
        return cmd_t'(b);
    endfunction

    function automatic port_state_e next_after_cmd(input cmd_t c);
        if (!c.two_byte)
            return ST_CMD;
        return c.is_read ? ST_RDATA : ST_WDATA;
    endfunction

endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_prev
);

    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= RST_VAL;
                    else     pipe[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= RST_VAL;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_prev <= RST_VAL;
        else     q_prev <= pipe[STAGES-1];
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/ccp_shifter.sv
module ccp_shifter
    import codec_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_act,
    input  logic          sclk_fall,
    input  logic          din,
    output logic [CW-1:0] bit_idx,
    output logic          byte_done,
    output logic [DW-1:0] byte_val
);

    logic [DW-1:0] sreg;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg      <= '0;
            cnt       <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!cs_act) begin
                cnt <= '0;
            end else if (sclk_fall) begin
                sreg <= {sreg[DW-2:0], din};
                cnt  <= cnt + 1'b1;
                if (cnt == CW'(DW - 1))
                    byte_done <= 1'b1;
            end
        end
    end

    assign bit_idx  = cnt;
    assign byte_val = sreg;

    AST_DONE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> (bit_idx == '0)); // R2
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (bit_idx == '0) && !byte_done); // R8

endmodule

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
    import codec_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_done,
    input  logic [DW-1:0] byte_val,
    output port_state_e   state,
    output logic          power,
    output logic [AW-1:0] cur_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data
);

    cmd_t cmd_in;
    assign cmd_in = unpack_cmd(byte_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_CMD;
            power    <= 1'b0;
            cur_addr <= '0;
        end else if (byte_done) begin
            unique case (state)
                ST_CMD: begin
                    power    <= cmd_in.pwr_up;
                    cur_addr <= cmd_in.addr;
                    state    <= next_after_cmd(cmd_in);
                end
                ST_WDATA, ST_RDATA: state <= ST_CMD;
                default:            state <= ST_CMD;
            endcase
        end
    end

    assign wr_en   = byte_done && (state == ST_WDATA);
    assign wr_data = byte_val;

    AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (state == ST_WDATA)); // R4
    AST_POWER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(byte_done && state == ST_CMD) |=> $stable(power)); // R3
    AST_BACK_TO_CMD: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state != ST_CMD) |=> (state == ST_CMD)); // R10

endmodule

// File: rtl/ccp_regfile.sv
module ccp_regfile
    import codec_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] flat
);

    logic [DW-1:0]   mem [NREG];
    logic [NREG-1:0] we_vec;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            assign we_vec[i] = wr_en && (addr == AW'(i));
            always_ff @(posedge clk) begin
                if (rst)            mem[i] <= '0;
                else if (we_vec[i]) mem[i] <= wr_data;
            end
            assign flat[i*DW +: DW] = mem[i];
        end
    endgenerate

    assign rd_data = mem[addr];

    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_vec)); // R4

endmodule

// File: rtl/ccp_txout.sv
module ccp_txout
    import codec_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_act,
    input  logic          sclk_rise,
    input  port_state_e   state,
    input  logic [CW-1:0] bit_idx,
    input  logic [DW-1:0] rd_data,
    output logic          sdo
);

    logic [CW-1:0] sel;
    assign sel = CW'(DW - 1) - bit_idx;

    always_ff @(posedge clk) begin
        if (rst || !cs_act)
            sdo <= 1'b0;
        else if (sclk_rise)
            sdo <= (state == ST_RDATA) ? rd_data[sel] : 1'b0;
    end

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !sdo); // R7

endmodule

// File: rtl/codec_ctl_port.sv
module codec_ctl_port
    import codec_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_i,
    input  logic               sdi_i,
    input  logic               csn_i,
    output logic               sdo_o,
    output logic               sdo_oe_o,
    output logic               powered_o,
    output logic [NREG*DW-1:0] regs_o
);

    localparam int NPIN = 3;

    logic [NPIN-1:0] pin_q, pin_qp;
    logic            cs_act, sclk_rise, sclk_fall, din;
    logic [CW-1:0]   bit_idx;
    logic            byte_done;
    logic [DW-1:0]   byte_val;
    port_state_e     state;
    logic [AW-1:0]   cur_addr;
    logic            wr_en;
    logic [DW-1:0]   wr_data, rd_data;

    ccp_sync #(
        .WIDTH  (NPIN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d     ({csn_i, sdi_i, sclk_i}),
        .q     (pin_q),
        .q_prev(pin_qp)
    );

    assign cs_act    = ~pin_q[2];
    assign din       =  pin_q[1];
    assign sclk_rise =  pin_q[0] & ~pin_qp[0];
    assign sclk_fall = ~pin_q[0] &  pin_qp[0];

    ccp_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .sclk_fall(sclk_fall),
        .din      (din),
        .bit_idx  (bit_idx),
        .byte_done(byte_done),
        .byte_val (byte_val)
    );

    ccp_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .byte_done(byte_done),
        .byte_val (byte_val),
        .state    (state),
        .power    (powered_o),
        .cur_addr (cur_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    ccp_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (cur_addr),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .flat   (regs_o)
    );

    ccp_txout u_tx (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .sclk_rise(sclk_rise),
        .state    (state),
        .bit_idx  (bit_idx),
        .rd_data  (rd_data),
        .sdo      (sdo_o)
    );

    assign sdo_oe_o = ~csn_i;

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDATA) |-> !wr_en); // R5

endmodule

// File: tb/codec_ctl_port_tb.sv
module codec_ctl_port_tb;

    localparam int HALF = 6;
    localparam int HOLD = 4;
    localparam int NV   = 11;

    // {command byte, second byte}
    localparam logic [15:0] VEC [NV] = '{
        {8'h80, 8'h00},  // one-byte power up                 R3
        {8'h9A, 8'hA5},  // write reg3 = A5                   R4
        {8'hFA, 8'h3C},  // write reg15 = 3C                  R4
        {8'h9E, 8'hFF},  // read reg3                         R5
        {8'hFE, 8'hFF},  // read reg15                        R5
        {8'h03, 8'h81},  // write reg0 = 81, bit0 set, pw 0   R9
        {8'h07, 8'hFF},  // read reg0, bit0 set               R9
        {8'hAC, 8'h00},  // one-byte with addr/read bits      R3
        {8'h52, 8'h5A},  // write reg10 = 5A                  R4
        {8'h56, 8'h00},  // read reg10                        R5
        {8'h00, 8'h00}   // one-byte power down               R3
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk_i = 1'b0;
    logic         sdi_i = 1'b0;
    logic         csn_i = 1'b1;
    logic         sdo_o, sdo_oe_o, powered_o;
    logic [127:0] regs_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [7:0] model [16];
    logic       m_pwr;

    always #2 clk = ~clk;

    codec_ctl_port u_dut (
        .clk      (clk),
        .rst      (rst),
        .sclk_i   (sclk_i),
        .sdi_i    (sdi_i),
        .csn_i    (csn_i),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o),
        .powered_o(powered_o),
        .regs_o   (regs_o)
    );

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] model_flat();
        logic [127:0] f;
        for (int i = 0; i < 16; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            sdi_i = b[i];
            ticks(HALF);
            sclk_i = 1'b1;
            ticks(HALF);
            rx[i] = sdo_o;
            sclk_i = 1'b0;
            ticks(HOLD);
        end
        ticks(HALF);
    endtask

    task automatic cs_low();
        csn_i = 1'b0;
        ticks(HALF);
    endtask

    task automatic cs_high();
        ticks(HALF);
        csn_i = 1'b1;
        ticks(HALF);
    endtask

    // Apply expected effect of a completed command to the model.
    task automatic model_cmd(input logic [7:0] c, input logic [7:0] d, output logic [7:0] exp_rx);
        m_pwr  = c[7];
        exp_rx = model[c[6:3]];
        if (c[1] && !c[2]) model[c[6:3]] = d;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        m_pwr = 1'b0;
        ticks(5);
        rst = 1'b0;
        ticks(5);
        // Reset state
        chk("R1 power after reset", 128'(powered_o), 128'(0));
        chk("R1 regs after reset", regs_o, 128'(0));
        chk("R7 oe with select high", 128'(sdo_oe_o), 128'(0));

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [7:0] c, d, rx, exp_rx;
            c = VEC[v][15:8];
            d = VEC[v][7:0];
            cs_low();
            chk("R7 oe with select low", 128'(sdo_oe_o), 128'(1));
            send_bits(c, 8, rx);
            if (c[1]) send_bits(d, 8, rx);
            cs_high();
            model_cmd(c, d, exp_rx);
            chk("R3/R4 power flag", 128'(powered_o), 128'(m_pwr));
            chk("R2/R4/R9 register file", regs_o, model_flat());
            if (c[1] && c[2]) chk("R5 read data MSB first", 128'(rx), 128'(exp_rx));
        end

        // R6: second byte in a separate select window
        begin
            logic [7:0] rx, e;
            cs_low(); send_bits(8'hAA, 8, rx); cs_high();
            chk("R6 no write before second byte", regs_o, model_flat());
            cs_low(); send_bits(8'h77, 8, rx); cs_high();
            model_cmd(8'hAA, 8'h77, e);
            chk("R6 split write reg5", regs_o, model_flat());
        end

        // R10: chained commands in one select window
        begin
            logic [7:0] rx, e;
            cs_low();
            send_bits(8'h8A, 8, rx); send_bits(8'h11, 8, rx);
            send_bits(8'h92, 8, rx); send_bits(8'h22, 8, rx);
            send_bits(8'h8E, 8, rx); send_bits(8'h00, 8, rx);
            cs_high();
            model_cmd(8'h8A, 8'h11, e);
            model_cmd(8'h92, 8'h22, e);
            model_cmd(8'h8E, 8'h00, e);
            chk("R10 chained writes", regs_o, model_flat());
            chk("R10 chained read", 128'(rx), 128'(8'h11));
        end

        // R8: abort inside data byte keeps pending write
        begin
            logic [7:0] rx, e;
            cs_low(); send_bits(8'hB2, 8, rx); send_bits(8'hFF, 3, rx); cs_high();
            chk("R8 partial data byte discarded", regs_o, model_flat());
            cs_low(); send_bits(8'hC3, 8, rx); cs_high();
            model_cmd(8'hB2, 8'hC3, e);
            chk("R8 pending write kept", regs_o, model_flat());
        end

        // R8: abort inside command byte
        begin
            logic [7:0] rx, e;
            chk("R8 power before abort", 128'(powered_o), 128'(1));
            cs_low(); send_bits(8'hFF, 5, rx); cs_high();
            cs_low(); send_bits(8'h00, 8, rx); cs_high();
            model_cmd(8'h00, 8'h00, e);
            chk("R8 partial command discarded", 128'(powered_o), 128'(m_pwr));
            chk("R8 registers untouched", regs_o, model_flat());
        end

        // R5: read with ones on sdi leaves registers alone, reads reg15
        begin
            logic [7:0] rx, e;
            cs_low(); send_bits(8'hFE, 8, rx); send_bits(8'hFF, 8, rx); cs_high();
            model_cmd(8'hFE, 8'hFF, e);
            chk("R5 read reg15 again", 128'(rx), 128'(e));
            chk("R5 read leaves registers", regs_o, model_flat());
        end

        // R1: reset mid-stream returns to idle
        begin
            logic [7:0] rx;
            cs_low(); send_bits(8'h9A, 8, rx);
            rst = 1'b1; ticks(3); rst = 1'b0;
            send_bits(8'h80, 8, rx); cs_high();
            chk("R1 command expected after reset", regs_o, 128'(0));
            chk("R1 reset then power up", 128'(powered_o), 128'(1));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule